// File: doc/BRIEF.md
# Execute and Memory Stage Reservation Tracker

This block decides, one cycle at a time, whether the next instruction may issue without fighting an earlier one for a pipeline stage. It keeps a short look-ahead of future stage occupancy for two pipelines that advance in step. The first is a four-stage execute pipe, shared by ALU and multiply work: first pass, second pass, third pass and execute writeback. The second is an independent four-stage memory pipe: address, first cache access, second cache access and memory writeback. Each instruction class reserves a fixed pattern of stage slots relative to its issue cycle. Some patterns hold a stage for more than one cycle. Memory operations also take the execute pipe's first stage in their first cycle.

On each cycle the candidate's pattern is compared with the reserved slots. If no slot is shared, the block raises its grant and folds the pattern into the look-ahead. If any slot is shared, it raises its stall and reserves nothing. On every clock edge the whole look-ahead moves one cycle closer to the present. The issue logic upstream holds a stalled instruction and presents it again; data dependencies and branch costs are handled elsewhere.

Top module: `rsv_tracker`

## Requirements
- R1: Class code 0 (simple) reserves the execute first stage at issue offset 0, the second stage at offset 1, the third stage at offset 2 and execute writeback at offset 3. Back-to-back simple issues never stall.
- R2: Class code 1 (two-pass) reserves the execute first stage at offsets 0 and 1, the second stage at 2, the third stage at 3 and writeback at 4. A request that needs the execute first stage in the cycle after a two-pass grant stalls.
- R3: Class code 2 (long multiply) reserves the execute first stage at offsets 0, 1 and 2, the second stage at 3, the third stage at 4 and writeback at 5 and 6. A simple request three cycles after it stalls on writeback and is granted in the next cycle.
- R4: Class code 3 (single memory access) reserves the address stage and the execute first stage at offset 0, then the first cache stage at 1, the second cache stage at 2 and memory writeback at 3.
- R5: Class code 4 (block memory access) reserves the first cache stage at offsets 1 and 2 and otherwise follows the R4 pattern shifted by that extra cycle: second cache stage at 3 and memory writeback at 4. A memory request in the next cycle stalls.
- R6: Class code 5 (control flow) reserves nothing. When requested it is always granted and never stalls.
- R7: Grant is high exactly when the request is valid and no slot of its pattern is already reserved. Stall is high exactly when the request is valid and at least one slot collides. A stalled request reserves nothing, and with no valid request both outputs are low.
- R8: Codes 6 to 15 reserve the same pattern as code 0.
- R9: Synchronous active-high reset clears every reservation. The first request after reset is granted, whatever it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | A candidate instruction is presented this cycle |
| req_cls | input | 4 | Occupancy class code of the candidate |
| req_go | output | 1 | Candidate may issue; its pattern is reserved at the clock edge |
| req_hold | output | 1 | Candidate collides with a reservation and must wait |

## Verification
Directed pairs separate the classes by the cycle in which a follower is released. After a two-pass grant, a follower waits one cycle. After a long multiply, a simple follower waits until the fourth cycle, and only the doubled writeback slot explains the wait at the third. A memory request after a two-pass grant stalls only because memory claims the execute first stage. Consecutive block transfers collide only in the doubled first cache slot. Control-flow requests interleaved with long multiplies show that they never stall. An unused code placed where only the simple pattern collides shows that it is decoded as simple. A reset in the middle of a long reservation shows that nothing survives. A long random stream with held stalled requests then compares both outputs with a slot-map model on every cycle.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    localparam int LOOKAHEAD = 8;
    localparam int NUM_RES   = 8;
    localparam int CLS_W     = 4;

    typedef enum logic [2:0] {
        RES_X1, RES_X2, RES_X3, RES_XWB,
        RES_MAG, RES_MD1, RES_MD2, RES_MWB
    } res_e;

    typedef enum logic [CLS_W-1:0] {
        CLS_SIMPLE  = 4'd0,
        CLS_TWOPASS = 4'd1,
        CLS_LONGMUL = 4'd2,
        CLS_MEMONE  = 4'd3,
        CLS_MEMBLK  = 4'd4,
        CLS_FLOW    = 4'd5
    } cls_e;

    typedef enum logic [2:0] {
        SHP_ONE, SHP_TWO, SHP_THREE, SHP_MEM, SHP_BLK, SHP_NONE
    } shape_e;

    typedef logic [LOOKAHEAD-1:0] slots_t;
    typedef slots_t [NUM_RES-1:0] occ_t;

    typedef struct packed {
        logic   vld;
        shape_e shape;
    } cand_t;

    // Map a class code to its occupancy shape; unused codes fall to the simple shape.
    function automatic shape_e shape_of(logic [CLS_W-1:0] code);
        case (code)
            CLS_TWOPASS: return SHP_TWO;
            CLS_LONGMUL: return SHP_THREE;
            CLS_MEMONE:  return SHP_MEM;
            CLS_MEMBLK:  return SHP_BLK;
            CLS_FLOW:    return SHP_NONE;
            default:     return SHP_ONE;
        endcase
    endfunction

    // A run of len reserved slots starting at offset first.
    function automatic slots_t span(int first, int len);
        slots_t v;
        v = '0;
        for (int k = 0; k < LOOKAHEAD; k++)
            if (k >= first && k < first + len) v[k] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/rsv_shape_gen.sv
module rsv_shape_gen
    import rsv_pkg::*;
(
    input  shape_e shape,
    output occ_t   pat
);
    int x1_len;
    int wb_len;
    int d1_len;

    always_comb begin
        pat    = '0;
        x1_len = 1;
        wb_len = 1;
        d1_len = 1;
        case (shape)
            SHP_ONE, SHP_TWO, SHP_THREE: begin
                if (shape == SHP_TWO)   x1_len = 2;
                if (shape == SHP_THREE) begin
                    x1_len = 3;
                    wb_len = 2;
                end
                pat[RES_X1]  = span(0, x1_len);
                pat[RES_X2]  = span(x1_len, 1);
                pat[RES_X3]  = span(x1_len + 1, 1);
                pat[RES_XWB] = span(x1_len + 2, wb_len);
            end
            SHP_MEM, SHP_BLK: begin
                if (shape == SHP_BLK) d1_len = 2;
                pat[RES_MAG] = span(0, 1);
                pat[RES_X1]  = span(0, 1);
                pat[RES_MD1] = span(1, d1_len);
                pat[RES_MD2] = span(1 + d1_len, 1);
                pat[RES_MWB] = span(2 + d1_len, 1);
            end
            default: pat = '0;
        endcase
    end
endmodule

// File: rtl/rsv_clash.sv
module rsv_clash
    import rsv_pkg::*;
(
    input  occ_t table_q,
    input  occ_t pat,
    output logic hit
);
    logic [NUM_RES-1:0] per_res;

    for (genvar r = 0; r < NUM_RES; r++) begin : g_res
        assign per_res[r] = |(table_q[r] & pat[r]);
    end

    assign hit = |per_res;
endmodule

// File: rtl/rsv_table.sv
module rsv_table
    import rsv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic commit,
    input  occ_t pat,
    output occ_t table_q
);
    for (genvar r = 0; r < NUM_RES; r++) begin : g_row
        slots_t merged;
        assign merged = table_q[r] | (commit ? pat[r] : '0);
        always_ff @(posedge clk) begin
            if (rst) table_q[r] <= '0;
            else     table_q[r] <= merged >> 1;
        end
    end
endmodule

// File: rtl/rsv_tracker.sv
module rsv_tracker
    import rsv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_vld,
    input  logic [CLS_W-1:0] req_cls,
    output logic             req_go,
    output logic             req_hold
);
    cand_t cand;
    occ_t  pat;
    occ_t  table_q;
    logic  hit;

    assign cand.vld   = req_vld;
    assign cand.shape = shape_of(req_cls);

    rsv_shape_gen u_shape (
        .shape (cand.shape),
        .pat   (pat)
    );

    rsv_clash u_clash (
        .table_q (table_q),
        .pat     (pat),
        .hit     (hit)
    );

    assign req_go   = cand.vld && !hit;
    assign req_hold = cand.vld && hit;

    rsv_table u_table (
        .clk     (clk),
        .rst     (rst),
        .commit  (req_go),
        .pat     (pat),
        .table_q (table_q)
    );
endmodule

// File: rtl/rsv_tracker_chk.sv
module rsv_tracker_chk
    import rsv_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_vld,
    input logic [CLS_W-1:0] req_cls,
    input logic             req_go,
    input logic             req_hold
);
    logic [2:0] since_rst;
    logic       uses_x1;
    logic       is_mem;
    logic       is_simple;

    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    assign uses_x1   = req_cls != CLS_FLOW;
    assign is_mem    = req_cls == CLS_MEMONE || req_cls == CLS_MEMBLK;
    assign is_simple = req_cls == CLS_SIMPLE || req_cls > CLS_FLOW;

    AST_GO_HOLD_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(req_go && req_hold)); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_vld |-> (!req_go && !req_hold)); // R7

    AST_VALID_DECIDED: assert property (@(posedge clk) disable iff (rst)
        req_vld |-> (req_go || req_hold)); // R7

    AST_FLOW_NEVER_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (req_vld && req_cls == CLS_FLOW) |-> req_go); // R6

    AST_TWOPASS_X1: assert property (@(posedge clk) disable iff (rst)
        (since_rst != 3'd0 && req_go && req_cls == CLS_TWOPASS) |=> !(req_go && uses_x1)); // R2

    AST_BLK_DC1: assert property (@(posedge clk) disable iff (rst)
        (since_rst != 3'd0 && req_go && req_cls == CLS_MEMBLK) |=> !(req_go && is_mem)); // R5

    AST_LONG_WB: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd3 && req_go && is_simple) |->
            !($past(req_go, 3) && $past(req_cls, 3) == CLS_LONGMUL)); // R3

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3'd0 && req_vld) |-> req_go); // R9
endmodule

bind rsv_tracker rsv_tracker_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_vld  (req_vld),
    .req_cls  (req_cls),
    .req_go   (req_go),
    .req_hold (req_hold)
);

// File: tb/rsv_tracker_test.sv
`timescale 1ns/1ps
module rsv_tracker_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_vld = 1'b0;
    logic [3:0] req_cls = 4'd0;
    logic       req_go;
    logic       req_hold;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    bit done = 0;
    bit busy [int];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rsv_tracker uut (
        .clk      (clk),
        .rst      (rst),
        .req_vld  (req_vld),
        .req_cls  (req_cls),
        .req_go   (req_go),
        .req_hold (req_hold)
    );

    // Slot list per class: entry = stage*16 + offset.
    // Stages: 0 ex-first, 1 ex-second, 2 ex-third, 3 ex-wb, 4 addr, 5 cache1, 6 cache2, 7 mem-wb.
    function automatic void slots(input int c, ref int q[$]);
        q.delete();
        case (c)
            1: q = '{0*16+0, 0*16+1, 1*16+2, 2*16+3, 3*16+4};
            2: q = '{0*16+0, 0*16+1, 0*16+2, 1*16+3, 2*16+4, 3*16+5, 3*16+6};
            3: q = '{4*16+0, 0*16+0, 5*16+1, 6*16+2, 7*16+3};
            4: q = '{4*16+0, 0*16+0, 5*16+1, 5*16+2, 6*16+3, 7*16+4};
            5: q = {};
            default: q = '{0*16+0, 1*16+1, 2*16+2, 3*16+3};
        endcase
    endfunction

    // One cycle: drive, compare against the model, commit on expected grant.
    // Returns the expected grant.
    task automatic step(input bit v, input int c, input string tag, output bit eg);
        int q[$];
        bit coll;
        @(posedge clk);
        #1;
        req_vld = v;
        req_cls = c[3:0];
        @(negedge clk);
        coll = 0;
        slots(c, q);
        foreach (q[i])
            if (busy.exists((cyc + (q[i] % 16)) * 8 + q[i] / 16)) coll = 1;
        eg = v && !coll;
        compared++;
        if (req_go !== eg || req_hold !== (v && coll)) begin
            mismatched++;
            $display("FAIL %s cycle %0d cls %0d: go/hold = %b%b, expected %b%b",
                     tag, cyc, c, req_go, req_hold, eg, v && coll);
        end
        if (eg) foreach (q[i]) busy[(cyc + (q[i] % 16)) * 8 + q[i] / 16] = 1;
    endtask

    task automatic go1(input bit v, input int c, input string tag);
        bit eg;
        step(v, c, tag, eg);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) go1(0, 0, "R7");
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst = 1'b1;
        req_vld = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        busy.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        bit eg;
        do_reset();
        idle(2);                                           // R7 idle outputs low
        for (int i = 0; i < 4; i++) go1(1, 0, "R1");       // R1 back-to-back simple
        idle(8);
        go1(1, 1, "R2"); go1(1, 0, "R2"); go1(1, 0, "R2"); // R2 one-cycle wait
        idle(8);
        go1(1, 2, "R3");                                   // R3 long then simple
        for (int i = 0; i < 4; i++) go1(1, 0, "R3");
        idle(8);
        go1(1, 1, "R4"); go1(1, 3, "R4"); go1(1, 3, "R4"); // R4 memory claims ex-first
        go1(1, 3, "R4"); go1(1, 0, "R4");
        idle(8);
        go1(1, 4, "R5"); go1(1, 3, "R5"); go1(1, 3, "R5"); // R5 doubled cache1
        go1(1, 4, "R5"); go1(1, 4, "R5"); go1(1, 4, "R5");
        idle(8);
        go1(1, 2, "R6");                                   // R6 flow during long
        for (int i = 0; i < 4; i++) go1(1, 5, "R6");
        go1(1, 2, "R6"); go1(1, 5, "R6");
        idle(8);
        go1(1, 2, "R8"); go1(0, 0, "R8"); go1(0, 0, "R8"); // R8 code 9 hits wb like simple
        go1(1, 9, "R8"); go1(1, 15, "R8");
        idle(8);
        go1(1, 1, "R8"); go1(1, 12, "R8");
        idle(8);
        go1(1, 2, "R9"); go1(1, 2, "R9");                  // R9 reset drops reservations
        do_reset();
        go1(1, 2, "R9"); go1(1, 0, "R9");
        idle(8);
        for (int n = 0; n < 400; n++) begin               // R7 random stream, stalled held
            int c;
            bit v;
            c = $urandom_range(0, 15);
            v = ($urandom_range(0, 3) != 0);
            step(v, c, "R7", eg);
            while (v && !eg) step(1, c, "R7", eg);
        end
        idle(4);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule